// File: doc/BRIEF.md
# Clock-Generator Control Register Slave (SMBus)

This block is the serial control port of a clock generator. It sits on a two-wire SMBus and gives a system controller read and write access to a small bank of 8-bit control bytes. The bytes drive output enables, drive strengths and stop-control masks elsewhere in the chip. Both bus lines are oversampled by the core clock, so no logic runs on the bus clock. The block pulls the data line low through one open-drain enable output.

A transaction starts with the device address. A write then carries a command byte. The top bit of the command picks single-byte or sequential (block) access, a two-bit select field must be zero, and the low five bits give the byte index for single-byte access. Block writes carry a byte count before the data. Block reads return the count of bytes in the bank first, and then the bytes themselves from index 0 upward. A read uses a repeated start after the command write.

Each control byte comes out of reset at its own default value. Byte 6 carries four strap bits from hardware in its low nibble. Byte 7 is a fixed identification value. Every accepted data write to an existing index gives a one-cycle strobe for that byte.

Top module: `smb_ctl_bank`

## Requirements
- R1: After reset, bytes 0..7 read as FFh, FFh, EBh, AFh, 03h, 00h, {0h, strap_i}, 18h (byte n is regs_o[8n+7:8n]), and sda_oe_o is 0.
- R2: The block acknowledges only the 7-bit address 69h (write form D2h, read form D3h). For any other address it does not acknowledge, and it ignores all traffic until the next start or stop.
- R3: A byte write sends command {1, 00, index[4:0]} and then one data byte. All three bytes are acknowledged, and the data lands in that byte.
- R4: A byte read (command write, repeated start, D3h) returns the byte at the commanded index, MSB first, and then ends on the master's NACK.
- R5: A block write (command bit 7 = 0) always starts at byte 0, whatever the offset bits hold. A count byte follows the command, and then up to that many data bytes are written to consecutive indices. A data byte beyond the count is not acknowledged and not written.
- R6: A block read returns 08h (the bank size) first, then byte 0, byte 1 and so on, while the master acknowledges.
- R7: When command bits 6:5 are not 00, the command byte is not acknowledged and no byte changes until the next start or stop.
- R8: Byte 6 bits 3:0 always show strap_i, and byte 7 always reads 18h (revision 1 in bits 7:4, vendor 8 in bits 3:0). Writes to those bits have no effect.
- R9: Reads at an index of 8 or more return FFh. Writes there are acknowledged but change nothing and give no strobe.
- R10: A read address received without a command accepted since the last stop is not acknowledged.
- R11: wr_stb_o bit n pulses high for exactly one cycle for every accepted data write to byte n (n < 8). Bits 3:0 of byte 6 and all of byte 7 are read-only, but writes to those bytes still strobe.
- R12: sda_oe_o is high only during an acknowledge slot the slave gives, or while it sends a 0 data bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, sampled |
| sda_i | input | 1 | Bus data line, sampled |
| strap_i | input | 4 | Hardware strap values shown in byte 6 bits 3:0 |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls the data line low |
| regs_o | output | 64 | All control bytes, byte n at bits 8n+7:8n |
| wr_stb_o | output | 8 | One-cycle write strobe per byte |

## Verification
The bench aims at these edges:
- Block reads are run past the end of the bank. A design that wraps the index would return byte 0 again where FFh is due.
- A block write carries a nonzero offset. A design that honours the offset would write the wrong byte.
- A block write sends more bytes than its count. A design that ignores the count would overwrite a third byte.
- Commands with a nonzero select field, and a wrong address, are each followed by data. A slave that acknowledges too early would alter the bank.
- Writes to the identification byte and to the strap nibble must leave both untouched.
- A bare read with no command before it must be refused, where a careless design would return stale data.

// File: rtl/smb_ctl_pkg.sv
package smb_ctl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CMD,
    PH_WCNT,
    PH_WDAT,
    PH_RD,
    PH_HOLD
  } phase_e;

  typedef enum logic [1:0] {
    SL_NONE,
    SL_SACK,
    SL_MACK
  } slot_e;

  localparam int CMD_OFS_W = 5;

endpackage

// File: rtl/smb_line_cond.sv
module smb_line_cond #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o
);

  logic [SYNC_STAGES-1:0] scl_sync_q, sda_sync_q;
  logic [SYNC_STAGES-1:0] scl_sync_n, sda_sync_n;
  logic                   scl_d_q, sda_d_q;
  logic                   scl_s, sda_s;

  always_comb begin
    scl_sync_n = {scl_sync_q[SYNC_STAGES-2:0], scl_i};
    sda_sync_n = {sda_sync_q[SYNC_STAGES-2:0], sda_i};
    scl_s      = scl_sync_q[SYNC_STAGES-1];
    sda_s      = sda_sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync_q <= '1;
      sda_sync_q <= '1;
      scl_d_q    <= 1'b1;
      sda_d_q    <= 1'b1;
    end else begin
      scl_sync_q <= scl_sync_n;
      sda_sync_q <= sda_sync_n;
      scl_d_q    <= scl_s;
      sda_d_q    <= sda_s;
    end
  end

  always_comb begin
    sda_o      = sda_s;
    scl_rise_o = scl_s & ~scl_d_q;
    scl_fall_o = ~scl_s & scl_d_q;
    start_o    = scl_s & scl_d_q & sda_d_q & ~sda_s;
    stop_o     = scl_s & scl_d_q & ~sda_d_q & sda_s;
  end

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank #(
  parameter int                 NREG    = 8,
  parameter int                 IDX_W   = 3,
  parameter int                 PTR_W   = 5,
  parameter logic [NREG*8-1:0]  RST_VAL = '1,
  parameter logic [NREG*8-1:0]  WR_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [7:0]        wr_data_i,
  input  logic [NREG*8-1:0] hw_i,
  input  logic [PTR_W-1:0]  rd_ptr_i,
  output logic [7:0]        rd_data_o,
  output logic [NREG*8-1:0] regs_o,
  output logic [NREG-1:0]   wr_stb_o
);

  logic [NREG-1:0] stb_n, wr_stb_q;

  for (genvar g = 0; g < NREG; g++) begin : g_byte
    localparam logic [7:0] M = WR_MASK[g*8 +: 8];
    logic [7:0] store_q, store_n;
    logic       hit;

    always_comb begin
      hit      = wr_en_i && (wr_idx_i == IDX_W'(g));
      store_n  = (wr_data_i & M) | (store_q & ~M);
      stb_n[g] = hit;
      regs_o[g*8 +: 8] = (store_q & M) | (hw_i[g*8 +: 8] & ~M);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        store_q <= RST_VAL[g*8 +: 8];
      end else if (hit) begin
        store_q <= store_n;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb_q <= '0;
    end else begin
      wr_stb_q <= stb_n;
    end
  end

  always_comb begin
    wr_stb_o  = wr_stb_q;
    rd_data_o = 8'hFF;
    for (int i = 0; i < NREG; i++) begin
      if (rd_ptr_i == PTR_W'(i)) rd_data_o = regs_o[i*8 +: 8];
    end
  end

  // R11
  stb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_stb_q));

  // R11
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb_q != '0) |=> (wr_stb_q == '0));

endmodule

// File: rtl/smb_proto_fsm.sv
module smb_proto_fsm
  import smb_ctl_pkg::*;
#(
  parameter int         NREG  = 8,
  parameter int         IDX_W = 3,
  parameter int         PTR_W = 5,
  parameter logic [6:0] ADDR7 = 7'h69
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             sda_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [7:0]       rd_data_i,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o,
  output logic             sda_oe_o
);

  localparam logic [PTR_W-1:0] PTR_MAX = '1;
  localparam logic [7:0]       CNT_VAL = 8'(NREG);

  phase_e           phase_q, phase_n;
  slot_e            slot_q, slot_n;
  logic [3:0]       bit_q, bit_n;
  logic [7:0]       sh_q, sh_n, tx_q, tx_n, left_q, left_n;
  logic             oe_q, oe_n, byteop_q, byteop_n, cmdok_q, cmdok_n;
  logic             sendcnt_q, sendcnt_n, mnack_q, mnack_n;
  logic [PTR_W-1:0] ptr_q, ptr_n, ptr_inc;
  logic             wr_en_q, wr_en_n;
  logic [IDX_W-1:0] wr_idx_q, wr_idx_n;
  logic [7:0]       wr_data_q, wr_data_n;
  logic             rx_phase;
  logic [7:0]       load_byte;

  always_comb begin
    phase_n   = phase_q;
    slot_n    = slot_q;
    bit_n     = bit_q;
    sh_n      = sh_q;
    tx_n      = tx_q;
    left_n    = left_q;
    oe_n      = oe_q;
    byteop_n  = byteop_q;
    cmdok_n   = cmdok_q;
    sendcnt_n = sendcnt_q;
    mnack_n   = mnack_q;
    ptr_n     = ptr_q;
    wr_en_n   = 1'b0;
    wr_idx_n  = wr_idx_q;
    wr_data_n = wr_data_q;
    rx_phase  = phase_q inside {PH_ADDR, PH_CMD, PH_WCNT, PH_WDAT};
    ptr_inc   = (ptr_q == PTR_MAX) ? ptr_q : ptr_q + 1'b1;
    load_byte = sendcnt_q ? CNT_VAL : rd_data_i;

    if (stop_i) begin
      phase_n = PH_IDLE;
      slot_n  = SL_NONE;
      oe_n    = 1'b0;
      cmdok_n = 1'b0;
    end else if (start_i) begin
      phase_n = PH_ADDR;
      slot_n  = SL_NONE;
      oe_n    = 1'b0;
      bit_n   = 4'd0;
    end else if (scl_rise_i) begin
      if (slot_q == SL_MACK) begin
        mnack_n = sda_i;
      end else if (rx_phase && slot_q == SL_NONE) begin
        sh_n  = {sh_q[6:0], sda_i};
        bit_n = bit_q + 4'd1;
      end
    end else if (scl_fall_i) begin
      if (slot_q == SL_SACK) begin
        slot_n = SL_NONE;
        if (phase_q == PH_RD) begin
          oe_n  = ~tx_q[7];
          bit_n = 4'd1;
        end else begin
          oe_n  = 1'b0;
          bit_n = 4'd0;
        end
      end else if (slot_q == SL_MACK) begin
        slot_n = SL_NONE;
        if (mnack_q) begin
          phase_n = PH_HOLD;
          oe_n    = 1'b0;
        end else begin
          tx_n  = load_byte;
          oe_n  = ~load_byte[7];
          bit_n = 4'd1;
          if (sendcnt_q) sendcnt_n = 1'b0;
          else           ptr_n     = ptr_inc;
        end
      end else if (phase_q == PH_RD) begin
        if (bit_q == 4'd8) begin
          oe_n   = 1'b0;
          slot_n = SL_MACK;
        end else begin
          tx_n  = {tx_q[6:0], 1'b0};
          oe_n  = ~tx_q[6];
          bit_n = bit_q + 4'd1;
        end
      end else if (rx_phase && bit_q == 4'd8) begin
        bit_n   = 4'd0;
        oe_n    = 1'b1;
        slot_n  = SL_SACK;
        unique case (phase_q)
          PH_ADDR: begin
            if (sh_q[7:1] != ADDR7 || (sh_q[0] && !cmdok_q)) begin
              phase_n = PH_HOLD;
              oe_n    = 1'b0;
              slot_n  = SL_NONE;
            end else if (sh_q[0]) begin
              phase_n = PH_RD;
              tx_n    = load_byte;
              if (sendcnt_q) sendcnt_n = 1'b0;
              else           ptr_n     = ptr_inc;
            end else begin
              phase_n = PH_CMD;
            end
          end
          PH_CMD: begin
            if (sh_q[6:5] != 2'b00) begin
              phase_n = PH_HOLD;
              oe_n    = 1'b0;
              slot_n  = SL_NONE;
              cmdok_n = 1'b0;
            end else begin
              cmdok_n   = 1'b1;
              byteop_n  = sh_q[7];
              sendcnt_n = ~sh_q[7];
              ptr_n     = sh_q[7] ? PTR_W'(sh_q[4:0]) : '0;
              left_n    = 8'd1;
              phase_n   = sh_q[7] ? PH_WDAT : PH_WCNT;
            end
          end
          PH_WCNT: begin
            left_n  = sh_q;
            phase_n = PH_WDAT;
          end
          default: begin
            if (left_q == 8'd0) begin
              phase_n = PH_HOLD;
              oe_n    = 1'b0;
              slot_n  = SL_NONE;
            end else begin
              left_n = left_q - 8'd1;
              ptr_n  = ptr_inc;
              if (ptr_q < PTR_W'(NREG)) begin
                wr_en_n   = 1'b1;
                wr_idx_n  = ptr_q[IDX_W-1:0];
                wr_data_n = sh_q;
              end
            end
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q   <= PH_IDLE;
      slot_q    <= SL_NONE;
      bit_q     <= 4'd0;
      sh_q      <= 8'd0;
      tx_q      <= 8'd0;
      left_q    <= 8'd0;
      oe_q      <= 1'b0;
      byteop_q  <= 1'b0;
      cmdok_q   <= 1'b0;
      sendcnt_q <= 1'b0;
      mnack_q   <= 1'b0;
      ptr_q     <= '0;
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= 8'd0;
    end else begin
      phase_q   <= phase_n;
      slot_q    <= slot_n;
      bit_q     <= bit_n;
      sh_q      <= sh_n;
      tx_q      <= tx_n;
      left_q    <= left_n;
      oe_q      <= oe_n;
      byteop_q  <= byteop_n;
      cmdok_q   <= cmdok_n;
      sendcnt_q <= sendcnt_n;
      mnack_q   <= mnack_n;
      ptr_q     <= ptr_n;
      wr_en_q   <= wr_en_n;
      wr_idx_q  <= wr_idx_n;
      wr_data_q <= wr_data_n;
    end
  end

  always_comb begin
    rd_ptr_o  = ptr_q;
    wr_en_o   = wr_en_q;
    wr_idx_o  = wr_idx_q;
    wr_data_o = wr_data_q;
    sda_oe_o  = oe_q;
  end

  // R12
  sda_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_q |-> (slot_q == SL_SACK) || (phase_q == PH_RD && slot_q == SL_NONE));

  // R3
  wr_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> (phase_q == PH_WDAT && slot_q == SL_SACK));

  // R7
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HOLD) |-> (!wr_en_q && !oe_q));

  // R12
  bit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_q <= 4'd8);

endmodule

// File: rtl/smb_ctl_bank.sv
module smb_ctl_bank #(
  parameter int                NREG        = 8,
  parameter logic [6:0]        ADDR7       = 7'h69,
  parameter logic [7:0]        ID_BYTE     = 8'h18,
  parameter int                SYNC_STAGES = 2,
  parameter int                STRAP_W     = 4,
  parameter logic [NREG*8-1:0] RST_VAL     = 64'h1800_0003_AFEB_FFFF,
  parameter logic [NREG*8-1:0] WR_MASK     = 64'h00F0_FFFF_FFFF_FFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  output logic               sda_oe_o,
  output logic [NREG*8-1:0]  regs_o,
  output logic [NREG-1:0]    wr_stb_o
);

  localparam int IDX_W = $clog2(NREG);
  localparam int PTR_W = smb_ctl_pkg::CMD_OFS_W;

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic              scl_rise, scl_fall, sda_s, start_det, stop_det;
  logic [PTR_W-1:0]  rd_ptr;
  logic [7:0]        rd_data, wr_data;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [NREG*8-1:0] hw_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  always_comb begin
    rst_core_n = rst_sync_q[1];
    hw_val     = '0;
    hw_val[NREG*8-1 -: 8]          = ID_BYTE;
    hw_val[(NREG-2)*8 +: STRAP_W]  = strap_i;
  end

  smb_line_cond #(.SYNC_STAGES(SYNC_STAGES)) u_line (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .sda_o     (sda_s),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  smb_proto_fsm #(.NREG(NREG), .IDX_W(IDX_W), .PTR_W(PTR_W), .ADDR7(ADDR7)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .scl_rise_i(scl_rise),
    .scl_fall_i(scl_fall),
    .sda_i     (sda_s),
    .start_i   (start_det),
    .stop_i    (stop_det),
    .rd_data_i (rd_data),
    .rd_ptr_o  (rd_ptr),
    .wr_en_o   (wr_en),
    .wr_idx_o  (wr_idx),
    .wr_data_o (wr_data),
    .sda_oe_o  (sda_oe_o)
  );

  smb_reg_bank #(.NREG(NREG), .IDX_W(IDX_W), .PTR_W(PTR_W),
                 .RST_VAL(RST_VAL), .WR_MASK(WR_MASK)) u_bank (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en_i  (wr_en),
    .wr_idx_i (wr_idx),
    .wr_data_i(wr_data),
    .hw_i     (hw_val),
    .rd_ptr_i (rd_ptr),
    .rd_data_o(rd_data),
    .regs_o   (regs_o),
    .wr_stb_o (wr_stb_o)
  );

endmodule

// File: tb/smb_ctl_bank_tb.sv
`timescale 1ns/1ps
module smb_ctl_bank_tb_top;

  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic [3:0]  strap = 4'h5;
  logic        sda_oe;
  logic [63:0] regs;
  logic [7:0]  stb;
  logic        sda_line;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] mdl [8];
  int exp_stb [8];
  int got_stb [8];
  logic [7:0] exp_q [$];
  logic [7:0] act_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  smb_ctl_bank dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .strap_i(strap), .sda_oe_o(sda_oe), .regs_o(regs), .wr_stb_o(stb)
  );

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_reg(int i);
    if (i == 7) return 8'h18;
    if (i == 6) return {mdl[6][7:4], strap};
    return mdl[i];
  endfunction

  function automatic void mdl_write(int i, logic [7:0] d);
    if (i < 8) begin
      exp_stb[i]++;
      if (i < 6) mdl[i] = d;
      else if (i == 6) mdl[6] = {d[7:4], 4'h0};
    end
  endfunction

  task automatic half();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; half(); scl = 1'b1; half(); sda_m = 1'b0; half(); scl = 1'b0; half();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; half(); scl = 1'b1; half(); sda_m = 1'b1; half(); half();
  endtask

  task automatic send(logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; half(); scl = 1'b1; half(); scl = 1'b0;
    end
    sda_m = 1'b1; half(); scl = 1'b1; half(); ack = ~sda_line; scl = 1'b0;
  endtask

  task automatic send_chk(logic [7:0] b, bit exp_ack, string req);
    bit a;
    send(b, a);
    check(a == exp_ack, req, {31'd0, a}, {31'd0, exp_ack});
  endtask

  task automatic recv(bit last, logic [7:0] exp, string req);
    logic [7:0] b;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; half(); scl = 1'b1; half(); b[i] = sda_line; scl = 1'b0;
    end
    sda_m = last; half(); scl = 1'b1; half(); scl = 1'b0;
    act_q.push_back(b);
  endtask

  task automatic check_regs(string req);
    for (int i = 0; i < 8; i++)
      check(regs[i*8 +: 8] == exp_reg(i), req, {24'd0, regs[i*8 +: 8]}, {24'd0, exp_reg(i)});
  endtask

  task automatic byte_write(int idx, logic [7:0] d, string req);
    bus_start();
    send_chk(8'hD2, 1'b1, "R2");
    send_chk({3'b100, 5'(idx)}, 1'b1, req);
    send_chk(d, 1'b1, req);
    bus_stop();
    mdl_write(idx, d);
  endtask

  task automatic byte_read(int idx, logic [7:0] exp, string req);
    bus_start();
    send_chk(8'hD2, 1'b1, "R2");
    send_chk({3'b100, 5'(idx)}, 1'b1, req);
    bus_start();
    send_chk(8'hD3, 1'b1, req);
    recv(1'b1, exp, req);
    bus_stop();
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] a, e;
        string t;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(a == e, t, {24'd0, a}, {24'd0, e});
      end
    end
  end

  // strobe monitor
  initial begin
    forever begin
      @(negedge clk);
      for (int i = 0; i < 8; i++) if (stb[i]) got_stb[i]++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    bit a;
    mdl[0] = 8'hFF; mdl[1] = 8'hFF; mdl[2] = 8'hEB; mdl[3] = 8'hAF;
    mdl[4] = 8'h03; mdl[5] = 8'h00; mdl[6] = 8'h00; mdl[7] = 8'h18;
    for (int i = 0; i < 8; i++) begin exp_stb[i] = 0; got_stb[i] = 0; end
    repeat (5) @(negedge clk);
    // R1 reset values
    check_regs("R1");
    check(sda_oe == 1'b0, "R1", {31'd0, sda_oe}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R3 byte write, R4 byte read
    byte_write(2, 8'h5A, "R3");
    check_regs("R3");
    byte_read(2, 8'h5A, "R4");
    byte_read(3, 8'hAF, "R4");

    // R8 read-only strap and ID
    byte_read(7, 8'h18, "R8");
    byte_read(6, {4'h0, strap}, "R8");
    byte_write(7, 8'hFF, "R8");
    byte_write(6, 8'hFF, "R8");
    check_regs("R8");

    // R5 block write
    bus_start();
    send_chk(8'hD2, 1'b1, "R2");
    send_chk(8'h00, 1'b1, "R5");
    send_chk(8'd3, 1'b1, "R5");
    send_chk(8'h11, 1'b1, "R5"); mdl_write(0, 8'h11);
    send_chk(8'h22, 1'b1, "R5"); mdl_write(1, 8'h22);
    send_chk(8'h33, 1'b1, "R5"); mdl_write(2, 8'h33);
    bus_stop();
    check_regs("R5");

    // R5 offset bits ignored in block mode
    bus_start();
    send_chk(8'hD2, 1'b1, "R2");
    send_chk(8'h05, 1'b1, "R5");
    send_chk(8'd1, 1'b1, "R5");
    send_chk(8'h44, 1'b1, "R5"); mdl_write(0, 8'h44);
    bus_stop();
    check_regs("R5");

    // R5 byte beyond count refused
    bus_start();
    send_chk(8'hD2, 1'b1, "R2");
    send_chk(8'h00, 1'b1, "R5");
    send_chk(8'd2, 1'b1, "R5");
    send_chk(8'h55, 1'b1, "R5"); mdl_write(0, 8'h55);
    send_chk(8'h66, 1'b1, "R5"); mdl_write(1, 8'h66);
    send_chk(8'h77, 1'b0, "R5");
    bus_stop();
    check_regs("R5");

    // R6 block read, R9 beyond the bank
    bus_start();
    send_chk(8'hD2, 1'b1, "R2");
    send_chk(8'h00, 1'b1, "R6");
    bus_start();
    send_chk(8'hD3, 1'b1, "R6");
    recv(1'b0, 8'h08, "R6");
    for (int i = 0; i < 8; i++) recv(1'b0, exp_reg(i), "R6");
    recv(1'b0, 8'hFF, "R9");
    recv(1'b1, 8'hFF, "R9");
    bus_stop();
    check(sda_oe == 1'b0, "R12", {31'd0, sda_oe}, 0);

    // R7 nonzero select field
    bus_start();
    send_chk(8'hD2, 1'b1, "R2");
    send_chk(8'hA2, 1'b0, "R7");
    send_chk(8'h00, 1'b0, "R7");
    bus_stop();
    check_regs("R7");

    // R2 wrong address
    bus_start();
    send_chk(8'hD4, 1'b0, "R2");
    send_chk(8'h82, 1'b0, "R2");
    send_chk(8'h00, 1'b0, "R2");
    bus_stop();
    check_regs("R2");

    // R9 index past the bank
    bus_start();
    send_chk(8'hD2, 1'b1, "R2");
    send_chk(8'h89, 1'b1, "R9");
    send_chk(8'h00, 1'b1, "R9");
    bus_stop();
    check_regs("R9");
    byte_read(12, 8'hFF, "R9");

    // R10 read with no command
    bus_start();
    send(8'hD3, a);
    check(a == 1'b0, "R10", {31'd0, a}, 0);
    bus_stop();
    check(sda_oe == 1'b0, "R12", {31'd0, sda_oe}, 0);

    repeat (20) @(negedge clk);
    // R11 strobe counts
    for (int i = 0; i < 8; i++)
      check(got_stb[i] == exp_stb[i], "R11", got_stb[i], exp_stb[i]);
    check(exp_q.size() == 0, "R6", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule